// File: doc/BRIEF.md
# Frame-Synchronous Payload Scrambler

This block whitens an OC-N byte stream before it goes out on the line, and it restores the stream on the receive side. Each byte is XORed with the next eight bits of a 7-bit linear feedback generator. The generator is reloaded to a fixed seed for every frame. The transport overhead bytes at the head of the first row bypass the XOR, so the framing pattern stays visible to the far end. XOR with a keystream undoes itself, so one instance of the block serves as both scrambler and descrambler.

A frame-start strobe on the input marks the first byte of a frame. An internal row and column tracker, sized by the parameter `N`, finds the bypassed bytes and moves on to the next frame by itself if no strobe arrives. Processed bytes leave one clock later, and the strobe is delayed by the same clock.

The tracker is a three-state machine:
- `ST_HUNT` means no frame start has been seen since reset.
- `ST_SKIP` covers a byte in the first-row overhead.
- `ST_MIX` covers a byte that is scrambled.

It has four transitions:
- Frame acquire: `ST_HUNT` to `ST_SKIP` when the strobe arrives.
- Overhead done: `ST_SKIP` to `ST_MIX` after the last first-row overhead column.
- Frame wrap: `ST_MIX` to `ST_SKIP` after the last byte of the ninth row.
- Marker override: any state to `ST_SKIP` whenever the strobe arrives.

Top module: `frame_scrambler`

## Requirements
- R1: A frame is 9 rows of 90*N bytes. In the first row, the first 3*N bytes leave the block unchanged.
- R2: Every other byte of a synchronised frame is XORed with keystream. This includes the overhead columns of rows 2 to 9.
- R3: The keystream comes from the generator x^7 + x^6 + 1 with an all-ones seed, applied most significant bit first. Its first bytes are 0xFE, 0x04, 0x18, and it repeats every 127 bytes.
- R4: The generator holds during bypassed bytes and restarts at the seed in every frame. The first scrambled byte of each frame is XORed with 0xFE.
- R5: A frame-start strobe at any position makes that byte row 1, column 1 of a new frame, and the generator restarts.
- R6: If no strobe arrives, the byte after the last byte of row 9 starts the next frame.
- R7: Output data lags input by one clock, and `out_sof` equals `in_sof` delayed by one clock.
- R8: After reset and before the first strobe, bytes pass through unchanged.
- R9: During reset, `out_data` is 0x00 and `out_sof` is 0.
- R10: Passing a stream through the block twice with the same frame alignment restores the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sof | input | 1 | High on the first byte of a frame |
| in_data | input | 8 | Input byte |
| out_sof | output | 1 | Frame-start strobe, delayed one clock |
| out_data | output | 8 | Scrambled or descrambled byte |

## Verification
The bench sends a whole all-zero frame and compares every output byte with a keystream it derives from the polynomial recurrence. A design that advanced the generator during overhead, skipped the lower-row overhead columns, or got the bit order wrong would show shifted or wrong bytes. It then lets a frame roll over without a strobe, and later asserts the strobe in the middle of a frame. A tracker that missed the wrap or ignored the override would not restart at 0xFE three bytes after the frame boundary. Finally it checks pass-through before the first strobe and round-trip recovery of a patterned stream. These catch a block that scrambles unsynchronised data, or one whose keystream depends on anything other than frame position.

// File: rtl/frame_scrambler_pkg.sv
package frame_scrambler_pkg;
    localparam int BYTE_W   = 8;
    localparam int GEN_W    = 7;
    localparam int GEN_TAP  = 6;
    localparam logic [GEN_W-1:0] GEN_SEED = '1;
    localparam int ROWS     = 9;
    localparam int TOH_PER_N = 3;
    localparam int COL_PER_N = 90;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_SKIP = 2'd1,
        ST_MIX  = 2'd2
    } pos_state_e;
endpackage

// File: rtl/fs_frame_tracker.sv
module fs_frame_tracker
    import frame_scrambler_pkg::*;
#(
    parameter int N = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    output logic key_en,
    output logic locked
);
    localparam int TOH_COLS  = TOH_PER_N * N;
    localparam int ROW_BYTES = COL_PER_N * N;
    localparam int CW = $clog2(ROW_BYTES);
    localparam int RW = $clog2(ROWS);

    pos_state_e    state_q, state_d, cur_st;
    logic [CW-1:0] col_q, col_d, cur_col, nxt_col;
    logic [RW-1:0] row_q, row_d, cur_row, nxt_row;
    logic          last_col;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    always_comb begin
        cur_st   = sof ? ST_SKIP : state_q;
        cur_col  = sof ? '0 : col_q;
        cur_row  = sof ? '0 : row_q;
        last_col = (cur_col == CW'(ROW_BYTES - 1));
        nxt_col  = last_col ? '0 : cur_col + 1'b1;
        nxt_row  = cur_row;
        if (last_col)
            nxt_row = (cur_row == RW'(ROWS - 1)) ? '0 : cur_row + 1'b1;
        state_d = ST_HUNT;
        col_d   = '0;
        row_d   = '0;
        unique case (cur_st)
            ST_HUNT: begin
                state_d = ST_HUNT;
            end
            ST_SKIP, ST_MIX: begin
                col_d   = nxt_col;
                row_d   = nxt_row;
                state_d = (nxt_row == '0 && nxt_col < CW'(TOH_COLS)) ? ST_SKIP : ST_MIX;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    always_comb begin
        key_en = (cur_st == ST_MIX);
        locked = (cur_st != ST_HUNT);
    end

    // R5
    sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> (row_q == '0 && col_q == CW'(1) && state_q == ST_SKIP));

    // R6
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && state_q == ST_MIX && row_q == RW'(ROWS - 1) && col_q == CW'(ROW_BYTES - 1))
        |=> (row_q == '0 && col_q == '0 && state_q == ST_SKIP));

    // R8
    hunt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !sof) |=> (state_q == ST_HUNT));
endmodule

// File: rtl/fs_keygen.sv
module fs_keygen
    import frame_scrambler_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [BYTE_W-1:0] key
);
    logic [GEN_W-1:0] state_q, state_d;

    always_comb begin
        logic [GEN_W-1:0] s;
        logic             fb;
        s   = state_q;
        key = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            key[BYTE_W-1-i] = s[GEN_W-1];
            fb = s[GEN_W-1] ^ s[GEN_TAP-1];
            s  = {s[GEN_W-2:0], fb};
        end
        state_d = adv ? s : GEN_SEED;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GEN_SEED;
        else        state_q <= state_d;
    end

    // R3
    gen_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R4
    seed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> (key == 8'hFE));
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
    import frame_scrambler_pkg::*;
#(
    parameter int N = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sof,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_sof,
    output logic [BYTE_W-1:0] out_data
);
    logic              key_en;
    logic              locked;
    logic [BYTE_W-1:0] key;
    logic              warm_q;

    fs_frame_tracker #(.N(N)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .sof    (in_sof),
        .key_en (key_en),
        .locked (locked)
    );

    fs_keygen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (key_en),
        .key   (key)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sof  <= 1'b0;
            out_data <= '0;
            warm_q   <= 1'b0;
        end else begin
            out_sof  <= in_sof;
            out_data <= key_en ? (in_data ^ key) : in_data;
            warm_q   <= 1'b1;
        end
    end

    // R7
    sof_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> (out_sof == $past(in_sof)));

    // R1
    bypass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && !$past(key_en)) |-> (out_data == $past(in_data)));

    // R8
    unlocked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q && !$past(locked)) |-> (out_data == $past(in_data)));
endmodule

// File: tb/frame_scrambler_test.sv
module frame_scrambler_test;
    localparam int N     = 1;
    localparam int TOH   = 3 * N;
    localparam int ROWB  = 90 * N;
    localparam int FRAME = 9 * ROWB;
    localparam int NVEC  = 3;
    // first payload bytes of a frame: {input, expected output}
    localparam logic [15:0] VEC [NVEC] = '{16'h00FE, 16'hFFFB, 16'h5A42};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_sof;
    logic [7:0] in_data;
    logic       out_sof;
    logic [7:0] out_data;
    int         checks = 0;
    int         fails  = 0;
    logic [7:0] ks [127];
    logic [7:0] saved [300];

    always #2 clk = ~clk;

    frame_scrambler #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_data(in_data),
        .out_sof(out_sof), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic s, input logic [7:0] d);
        @(negedge clk);
        in_sof  = s;
        in_data = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] key_at(input int pos);
        if (pos < TOH) return 8'h00;
        return ks[(pos - TOH) % 127];
    endfunction

    initial begin
        logic b [127*8];
        for (int i = 0; i < 127 * 8; i++)
            b[i] = (i < 7) ? 1'b1 : (b[i-6] ^ b[i-7]);
        for (int k = 0; k < 127; k++)
            for (int j = 0; j < 8; j++)
                ks[k][7-j] = b[k*8 + j];
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_sof = 1'b0; in_data = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        chk("R9 data", out_data, 8'h00);
        chk("R9 sof", {7'd0, out_sof}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R8: no frame start yet
        push(1'b0, 8'hA5); chk("R8", out_data, 8'hA5);
        push(1'b0, 8'h3C); chk("R8", out_data, 8'h3C);

        // R1, R7: first-row overhead passes, strobe delayed
        push(1'b1, 8'h11); chk("R1", out_data, 8'h11); chk("R7", {7'd0, out_sof}, 8'h01);
        push(1'b0, 8'h22); chk("R1", out_data, 8'h22); chk("R7", {7'd0, out_sof}, 8'h00);
        push(1'b0, 8'h33); chk("R1", out_data, 8'h33);
        for (int i = 0; i < NVEC; i++) begin
            push(1'b0, VEC[i][15:8]);
            chk("R3 vector", out_data, VEC[i][7:0]);
        end

        // R2, R3, R4: full all-zero frame
        for (int p = 0; p < FRAME; p++) begin
            push(p == 0, 8'h00);
            chk("R2 zero frame", out_data, key_at(p));
        end
        // R6: roll into next frame without a strobe
        for (int p = 0; p < 200; p++) begin
            push(1'b0, 8'h00);
            chk("R6 wrap", out_data, key_at(p));
        end
        // R5: strobe mid-frame
        for (int p = 0; p < 12; p++) begin
            push(p == 0, 8'h00);
            chk("R5 override", out_data, key_at(p));
        end
        // R10: two passes restore input
        for (int p = 0; p < 300; p++) begin
            push(p == 0, 8'((p * 37 + 5) & 8'hFF));
            saved[p] = out_data;
        end
        for (int p = 0; p < 300; p++) begin
            push(p == 0, saved[p]);
            chk("R10 round trip", out_data, 8'((p * 37 + 5) & 8'hFF));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule